// File: doc/BRIEF.md
# Triple-Voted Pixel Configuration Chain

This block holds the configuration of a row of pixel front-ends in a serial shift chain in which every stored bit is kept in three flip-flops. The three copies are resolved through a bitwise majority vote. On every clock edge all three copies are rewritten from the voted value, so an upset in one copy is repaired at the next edge and never reaches an output. Loading is serial: data enters at one end of the chain on each enabled shift-clock edge, and the voted value of the far end leaves at the other end. That output allows chains to be daisy-chained and the configuration to be read back.

The chain starts with a shared 8-bit injection amplitude code. One segment per pixel follows it. Each segment holds a 3-bit threshold trim, a 5-bit shaper DC-level trim, an injection enable and a trigger-source select. The decoded fields come straight from the voted bits. The block also forms each pixel's trigger: the trigger follows that pixel's comparator when the select is 1 and is held high when the select is 0. The parameter `NUM_PIX` sets the number of pixels.

Top module: `tmr_cfg_chain`

## Requirements
- R1: While `rst_n` is low, all three copies of every bit are cleared. This happens asynchronously. As a result `sdo`, every decoded field and `inj_amp` read 0, and every `trig_out` bit reads 1.
- R2: On a rising `clk` edge with `shift_en` high, the chain moves by one place toward `sdo`. `sdi` enters at chain bit 0, and `sdo` shows voted chain bit L-1, where L = 8 + 10*NUM_PIX. A bit therefore appears on `sdo` after L enabled edges.
- R3: On an edge with `shift_en` low, `sdi` is ignored. `sdo` and all decoded fields keep their values.
- R4: `inj_amp` is voted chain bits [7:0].
- R5: Pixel p's segment starts at chain bit 8+10*p. The threshold trim `thr_trim[3p+2:3p]` is segment bits [2:0].
- R6: The DC-level trim `dc_trim[5p+4:5p]` is segment bits [7:3].
- R7: `inj_en[p]` is segment bit 8.
- R8: `ext_sel[p]` is segment bit 9. When it is 1, `trig_out[p]` equals `cmp_in[p]`. When it is 0, `trig_out[p]` is 1.
- R9: Corrupting every bit of any one copy leaves `sdo`, all fields and all triggers unchanged.
- R10: One clock edge after a copy is corrupted, that copy has been rewritten from the vote. A later corruption of a second copy is then also masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | shift clock |
| rst_n | input | 1 | asynchronous active-low clear of all copies |
| shift_en | input | 1 | shift enable; when low the chain only scrubs |
| sdi | input | 1 | serial data in (enters chain bit 0) |
| sdo | output | 1 | voted last chain bit, for daisy-chain and read-back |
| cmp_in | input | NUM_PIX | per-pixel comparator outputs |
| inj_amp | output | 8 | injection amplitude code |
| thr_trim | output | 3*NUM_PIX | threshold trims, pixel p at [3p+2:3p] |
| dc_trim | output | 5*NUM_PIX | DC-level trims, pixel p at [5p+4:5p] |
| inj_en | output | NUM_PIX | per-pixel injection enables |
| ext_sel | output | NUM_PIX | per-pixel trigger-source selects |
| trig_out | output | NUM_PIX | per-pixel trigger |

## Verification
Only one register stage lies between the inputs and the outputs. `sdo` and every decoded field therefore take their new value at the enabled edge that shifts the bit in. The bench model advances on the same edge, and all outputs are compared at the following falling edge. `trig_out` is combinational from `cmp_in` and the voted select. The bench changes `cmp_in` just after the rising edge, so the trigger has settled well before the falling-edge comparison. The corruption tests act through the same window. A copy is corrupted after a falling edge, its outputs are checked within that half cycle, and the second corruption is applied only after one scrubbing edge has passed.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;

  localparam int AMP_W = 8;
  localparam int THR_W = 3;
  localparam int DC_W  = 5;
  localparam int SEG_W = THR_W + DC_W + 2;

  function automatic int chain_len(input int num_pix);
    return AMP_W + num_pix * SEG_W;
  endfunction

  function automatic int seg_base(input int pix);
    return AMP_W + pix * SEG_W;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q
);

  logic [LEN-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = q_r;

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int LEN = 48
) (
  input  logic [LEN-1:0] a,
  input  logic [LEN-1:0] b,
  input  logic [LEN-1:0] c,
  output logic [LEN-1:0] v
);
  import tmr_cfg_pkg::*;

  for (genvar i = 0; i < LEN; i++) begin : g_bit
    assign v[i] = maj3(a[i], b[i], c[i]);
  end

endmodule

// File: rtl/pix_decode.sv
module pix_decode
  import tmr_cfg_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic             cmp,
  output logic [THR_W-1:0] thr,
  output logic [DC_W-1:0]  dc,
  output logic             inj,
  output logic             ext,
  output logic             trig
);

  localparam int DC_LO  = THR_W;
  localparam int INJ_AT = THR_W + DC_W;
  localparam int EXT_AT = INJ_AT + 1;

  always_comb begin
    thr  = seg[THR_W-1:0];
    dc   = seg[DC_LO +: DC_W];
    inj  = seg[INJ_AT];
    ext  = seg[EXT_AT];
    trig = ext ? cmp : 1'b1;
  end

endmodule

// File: rtl/tmr_cfg_chain.sv
module tmr_cfg_chain
  import tmr_cfg_pkg::*;
#(
  parameter int NUM_PIX = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic                     sdi,
  output logic                     sdo,
  input  logic [NUM_PIX-1:0]       cmp_in,
  output logic [AMP_W-1:0]         inj_amp,
  output logic [NUM_PIX*THR_W-1:0] thr_trim,
  output logic [NUM_PIX*DC_W-1:0]  dc_trim,
  output logic [NUM_PIX-1:0]       inj_en,
  output logic [NUM_PIX-1:0]       ext_sel,
  output logic [NUM_PIX-1:0]       trig_out
);

  localparam int LEN = chain_len(NUM_PIX);

  logic [2:0][LEN-1:0] bank_q;
  logic [LEN-1:0]      vote;
  logic [LEN-1:0]      next_word;

  assign next_word = shift_en ? {vote[LEN-2:0], sdi} : vote;

  for (genvar k = 0; k < 3; k++) begin : g_copy
    tmr_bank #(.LEN(LEN)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (next_word),
      .q     (bank_q[k])
    );
  end

  tmr_voter #(.LEN(LEN)) u_vote (
    .a (bank_q[0]),
    .b (bank_q[1]),
    .c (bank_q[2]),
    .v (vote)
  );

  assign sdo     = vote[LEN-1];
  assign inj_amp = vote[AMP_W-1:0];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    pix_decode u_dec (
      .seg  (vote[seg_base(p) +: SEG_W]),
      .cmp  (cmp_in[p]),
      .thr  (thr_trim[p*THR_W +: THR_W]),
      .dc   (dc_trim[p*DC_W +: DC_W]),
      .inj  (inj_en[p]),
      .ext  (ext_sel[p]),
      .trig (trig_out[p])
    );
  end

endmodule

// File: rtl/tmr_cfg_chain_chk.sv
module tmr_cfg_chain_chk
  import tmr_cfg_pkg::*;
#(
  parameter int NUM_PIX = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          shift_en,
  input logic                          sdi,
  input logic                          sdo,
  input logic [chain_len(NUM_PIX)-1:0] vote,
  input logic [NUM_PIX-1:0]            ext_sel,
  input logic [NUM_PIX-1:0]            cmp_in,
  input logic [NUM_PIX-1:0]            trig_out
);

  localparam int LEN = chain_len(NUM_PIX);

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> (vote == '0))
    else $error("p_reset_clear_r1");

  p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (vote == {$past(vote[LEN-2:0]), $past(sdi)}))
    else $error("p_shift_move_r2");

  p_sdo_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sdo == $past(vote[LEN-2])))
    else $error("p_sdo_follow_r2");

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(vote))
    else $error("p_hold_r3");

  p_trig_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~trig_out & ~ext_sel) == 0)
    else $error("p_trig_high_r8");

  p_trig_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_out ^ cmp_in) & ext_sel) == '0)
    else $error("p_trig_follow_r8");

endmodule

bind tmr_cfg_chain tmr_cfg_chain_chk #(.NUM_PIX(NUM_PIX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .sdi      (sdi),
  .sdo      (sdo),
  .vote     (vote),
  .ext_sel  (ext_sel),
  .cmp_in   (cmp_in),
  .trig_out (trig_out)
);

// File: tb/tmr_cfg_chain_test.sv
`timescale 1ns/1ps
module tmr_cfg_chain_test;
  localparam int NP  = 4;
  localparam int L   = 8 + 10 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic sdi = 1'b0;
  logic [NP-1:0] cmp_in = '0;
  logic sdo;
  logic [7:0] inj_amp;
  logic [NP*3-1:0] thr_trim;
  logic [NP*5-1:0] dc_trim;
  logic [NP-1:0] inj_en, ext_sel, trig_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [L-1:0] m;

  always #2 clk = ~clk;

  tmr_cfg_chain #(.NUM_PIX(NP)) uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
    .cmp_in(cmp_in), .inj_amp(inj_amp), .thr_trim(thr_trim), .dc_trim(dc_trim),
    .inj_en(inj_en), .ext_sel(ext_sel), .trig_out(trig_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: a plain bit vector shifted on enabled edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m <= '0;
    else if (shift_en) m <= {m[L-2:0], sdi};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cmp_in <= NP'((cyc * 5) ^ (cyc >> 2));
  end

  task automatic compare_all();
    chk("R2 sdo", 32'(sdo), 32'(m[L-1]));
    chk("R4 amp", 32'(inj_amp), 32'(m[7:0]));
    for (int p = 0; p < NP; p++) begin
      int b = 8 + 10 * p;
      chk("R5 thr", 32'(thr_trim[p*3 +: 3]), 32'(m[b +: 3]));
      chk("R6 dc", 32'(dc_trim[p*5 +: 5]), 32'(m[b+3 +: 5]));
      chk("R7 inj", 32'(inj_en[p]), 32'(m[b+8]));
      chk("R8 ext", 32'(ext_sel[p]), 32'(m[b+9]));
      chk("R8 trig", 32'(trig_out[p]), 32'(m[b+9] ? cmp_in[p] : 1'b1));
    end
  endtask

  always @(negedge clk) if (rst_n) compare_all();

  function automatic logic [L-1:0] mk_word(input int s);
    logic [L-1:0] w = '0;
    w[7:0] = 8'(s * 37 + 5);
    for (int p = 0; p < NP; p++) begin
      int b = 8 + 10 * p;
      w[b +: 3]  = 3'(p + s);
      w[b+3 +: 5] = 5'(p * 7 + s * 3);
      w[b+8] = 1'((p + s) & 1);
      w[b+9] = 1'(((p + s) >> 1) & 1);
    end
    return w;
  endfunction

  task automatic shift_word(input logic [L-1:0] w, input logic [L-1:0] prev, input bit rb);
    for (int i = L - 1; i >= 0; i--) begin
      @(negedge clk);
      if (rb) chk("R2 readback", 32'(sdo), 32'(prev[i]));
      shift_en = 1'b1;
      sdi = w[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1 sdo", 32'(sdo), 0);
    chk("R1 amp", 32'(inj_amp), 0);
    chk("R1 thr", 32'(thr_trim), 0);
    chk("R1 dc", 32'(dc_trim), 0);
    chk("R1 inj", 32'(inj_en), 0);
    chk("R1 ext", 32'(ext_sel), 0);
    chk("R1 trig", 32'(trig_out), 32'({NP{1'b1}}));
  endtask

  logic [L-1:0] w1, w2;
  logic [63:0] snap;

  initial begin
    w1 = mk_word(3);
    w2 = ~mk_word(6);
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    shift_word(w1, '0, 1'b1);
    chk("R4 amp loaded", 32'(inj_amp), 32'(w1[7:0]));
    shift_word(w2, w1, 1'b1);
    chk("R5 thr loaded", 32'(thr_trim[2:0]), 32'(w2[10:8]));

    // hold: sdi toggles with shift disabled
    snap = {sdo, inj_amp, thr_trim, dc_trim, inj_en, ext_sel};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sdi = ~sdi;
    end
    @(negedge clk);
    chk("R3 hold", 32'(snap != {sdo, inj_amp, thr_trim, dc_trim, inj_en, ext_sel}), 0);

    // single-copy corruption, then a second copy after one scrub edge
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      case (k)
        0: force uut.g_copy[0].u_bank.q_r = '1;
        1: force uut.g_copy[1].u_bank.q_r = '0;
        default: force uut.g_copy[2].u_bank.q_r = '1;
      endcase
      #0.5;
      case (k)
        0: release uut.g_copy[0].u_bank.q_r;
        1: release uut.g_copy[1].u_bank.q_r;
        default: release uut.g_copy[2].u_bank.q_r;
      endcase
      #0.5;
      chk("R9 masked", 32'(snap != {sdo, inj_amp, thr_trim, dc_trim, inj_en, ext_sel}), 0);
    end
    @(negedge clk);
    force uut.g_copy[1].u_bank.q_r = '1;
    #0.5;
    release uut.g_copy[1].u_bank.q_r;
    @(negedge clk);
    force uut.g_copy[0].u_bank.q_r = '1;
    #0.5;
    release uut.g_copy[0].u_bank.q_r;
    #0.5;
    chk("R10 scrubbed", 32'(snap != {sdo, inj_amp, thr_trim, dc_trim, inj_en, ext_sel}), 0);

    // corruption while shifting is also voted away
    @(negedge clk);
    force uut.g_copy[2].u_bank.q_r = '0;
    #0.5;
    release uut.g_copy[2].u_bank.q_r;
    shift_word(mk_word(9), w2, 1'b1);

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    shift_word(mk_word(1), '0, 1'b1);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule